// File: doc/BRIEF.md
# Eight-Bit Arithmetic Logic Unit with Status Flags

This block is a purely combinational arithmetic logic unit. It takes two 8-bit operands, `op_a` and `op_b`, and a 4-bit opcode. It produces an 8-bit result and four status flags: overflow, zero, carry and negative.

There are twelve operations, in three groups:

- Four arithmetic operations share a single adder.
- Four bitwise logic operations.
- A miscellaneous group: multiply-by-eight, a signed remainder by 16 that keeps the sign of `op_a`, a logical shift left and a rotate right.

Each group has its own policy for the flags. Any opcode outside the twelve gives an all-zero output.

The two high opcode bits select the group and the two low bits select the operation within it. This keeps the operand steering of the shared adder and the flag gating shallow. The block holds no state, so a change on any input reaches the outputs within the same cycle of whatever logic surrounds it.

Top module: `alu8_core`

## Requirements
- R1: Opcode 4'h0 (add) gives result = (A+B) mod 256, C = carry out of bit 7, and V = two's-complement overflow.
- R2: Opcode 4'h1 (subtract) computes A + ~B + 1, giving result = (A-B) mod 256. C is the carry out of that sum (1 when A >= B unsigned), and V flags signed overflow of A-B.
- R3: Opcode 4'h2 (decrement) gives result = A-1, computed as A + 8'hFF. C = 1 exactly when A != 0, and V = 1 exactly when A = 8'h80.
- R4: Opcode 4'h3 (negate) gives result = ~A + 1. C = 1 exactly when A = 0, and V = 1 exactly when A = 8'h80.
- R5: For every opcode in 4'h0 to 4'h9, Z = 1 exactly when the result is zero and N = result bit 7.
- R6: Opcodes 4'h4, 4'h5, 4'h6 and 4'h7 give A OR B, A NAND B, A XNOR B and NOT A respectively, with V = C = 0.
- R7: Opcode 4'h8 gives the low 8 bits of B shifted left by three places, with V = C = 0.
- R8: Opcode 4'h9 gives A remainder 16 under truncated division. The result is {4'hF, A[3:0]} when A[7] = 1 and A[3:0] != 0, and {4'h0, A[3:0]} otherwise; for example 8'hCB (-53) gives 8'hFB (-5). V = C = 0.
- R9: Opcode 4'hA gives {B[6:0], 0} and opcode 4'hB gives {B[0], B[7:1]}. Both force V, Z, C and N to 0.
- R10: Opcodes 4'hC to 4'hF give result 0 with all four flags 0.
- R11: The outputs follow any input change without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 8 | First operand (A) |
| op_b | input | 8 | Second operand (B) |
| opcode | input | 4 | Operation select: bits [3:2] select the group, bits [1:0] the operation |
| result | output | 8 | Operation result |
| flag_v | output | 1 | Signed overflow |
| flag_z | output | 1 | Result is zero |
| flag_c | output | 1 | Carry out of bit 7 |
| flag_n | output | 1 | Result bit 7 |

## Verification
The arithmetic operations are tried with operand pairs placed at the signed and unsigned wrap points: 8'h7F, 8'h80, 8'hFF, 8'h00 and 8'h01. These pairs separate carry from overflow and expose a swapped or inverted adder input. Alternating-bit and single-bit patterns (8'hAA, 8'h55, 8'h01, 8'h80) tell the logic operations apart from one another and catch a wrong shift direction or a lost rotate bit. The remainder is driven with negative values whose low nibble is zero and nonzero, and with positive values, which separates the sign-fill rule from a plain mask. Every unused opcode is driven with nonzero operands, to show that no stale group output leaks through.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   // Opcode bits [3:2] choose the operation group
   typedef enum logic [1:0] {
      GRP_ARITH = 2'b00,
      GRP_LOGIC = 2'b01,
      GRP_MISC  = 2'b10,
      GRP_NONE  = 2'b11
   } alu_grp_e;

   // Opcode bits [1:0] inside the arithmetic group
   typedef enum logic [1:0] {
      AM_ADD = 2'b00,
      AM_SUB = 2'b01,
      AM_DEC = 2'b10,
      AM_NEG = 2'b11
   } arith_mode_e;

   // Opcode bits [1:0] inside the miscellaneous group
   localparam logic [1:0] MS_MUL8 = 2'b00;
   localparam logic [1:0] MS_REM  = 2'b01;
   localparam logic [1:0] MS_SHL  = 2'b10;
   localparam logic [1:0] MS_ROR  = 2'b11;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
   import alu8_pkg::*;
#(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   mode,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);
   localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] x, y;
   logic         cin;

   if (W < 2) begin : g_bad_width
      $error("alu8_addsub: W must be at least 2");
   end

   // Operand steering for the four arithmetic operations
   always_comb begin
      x   = a;
      y   = b;
      cin = 1'b0;
      case (arith_mode_e'(mode))
         AM_ADD: begin x = a;  y = b;          cin = 1'b0; end
         AM_SUB: begin x = a;  y = ~b;         cin = 1'b1; end
         AM_DEC: begin x = a;  y = {W{1'b1}};  cin = 1'b0; end
         AM_NEG: begin x = ~a; y = '0;         cin = 1'b1; end
         default: ;
      endcase
   end

   if (RIPPLE) begin : g_ripple
      logic [W:0] cy;
      assign cy[0] = cin;
      for (genvar i = 0; i < W; i++) begin : g_fa
         assign sum[i]  = x[i] ^ y[i] ^ cy[i];
         assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
      end
      assign cout = cy[W];
   end else begin : g_infer
      assign {cout, sum} = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
   end

   assign ovf = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);

   always_comb begin
      if (arith_mode_e'(mode) == AM_DEC) begin
         AST_DEC_CARRY: assert (cout == (a != '0)) else $error("dec carry");   // R3
         AST_DEC_OVF: assert (ovf == (a == MIN_NEG)) else $error("dec ovf");   // R3
      end
      if (arith_mode_e'(mode) == AM_NEG) begin
         AST_NEG_CARRY: assert (cout == (a == '0)) else $error("neg carry");   // R4
         AST_NEG_OVF: assert (ovf == (a == MIN_NEG)) else $error("neg ovf");   // R4
      end
   end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   sel,
   output logic [W-1:0] y
);
   always_comb begin
      case (sel)
         2'b00:   y = a | b;
         2'b01:   y = ~(a & b);
         2'b10:   y = ~(a ^ b);
         default: y = ~a;
      endcase
   end
endmodule

// File: rtl/alu8_misc.sv
module alu8_misc
   import alu8_pkg::*;
#(
   parameter int W         = 8,
   parameter int REM_BITS  = 4,
   parameter int MUL_SHIFT = 3
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   sel,
   output logic [W-1:0] y
);
   localparam int HI_BITS = W - REM_BITS;

   logic [REM_BITS-1:0] low;
   logic                neg_rem;
   logic [W-1:0]        rem_val;

   if (REM_BITS < 1 || REM_BITS >= W) begin : g_bad_rem
      $error("alu8_misc: REM_BITS must lie in 1..W-1");
   end
   if (MUL_SHIFT < 1 || MUL_SHIFT >= W) begin : g_bad_mul
      $error("alu8_misc: MUL_SHIFT must lie in 1..W-1");
   end

   // Truncated remainder by 2**REM_BITS: a negative value with a nonzero
   // low field stays negative, so the upper bits are filled with ones.
   assign low     = a[REM_BITS-1:0];
   assign neg_rem = a[W-1] & (|low);
   assign rem_val = {{HI_BITS{neg_rem}}, low};

   always_comb begin
      case (sel)
         MS_MUL8: y = b << MUL_SHIFT;
         MS_REM:  y = rem_val;
         MS_SHL:  y = {b[W-2:0], 1'b0};
         default: y = {b[0], b[W-1:1]};
      endcase
   end

   always_comb begin
      if (sel == MS_REM) begin
         AST_REM_SIGN: assert (!(a[W-1] && !y[W-1] && y != '0)) else $error("rem sign");   // R8
         AST_REM_POS: assert (a[W-1] || !y[W-1]) else $error("rem pos");                   // R8
      end
   end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int W         = 8,
   parameter int REM_BITS  = 4,
   parameter int MUL_SHIFT = 3,
   parameter bit RIPPLE    = 1'b0
) (
   input  logic [7:0] op_a,
   input  logic [7:0] op_b,
   input  logic [3:0] opcode,
   output logic [7:0] result,
   output logic       flag_v,
   output logic       flag_z,
   output logic       flag_c,
   output logic       flag_n
);
   if (W != 8) begin : g_bad_port
      $error("alu8_core: the port widths are fixed at 8 bits");
   end

   alu_grp_e     grp;
   logic [1:0]   sub_op;
   logic [W-1:0] sum_q, log_q, misc_q;
   logic         add_c, add_v;
   logic         zn_en;

   assign grp    = alu_grp_e'(opcode[3:2]);
   assign sub_op = opcode[1:0];

   alu8_addsub #(.W(W), .RIPPLE(RIPPLE)) u_add (
      .a(op_a), .b(op_b), .mode(sub_op), .sum(sum_q), .cout(add_c), .ovf(add_v)
   );

   alu8_logic #(.W(W)) u_log (
      .a(op_a), .b(op_b), .sel(sub_op), .y(log_q)
   );

   alu8_misc #(.W(W), .REM_BITS(REM_BITS), .MUL_SHIFT(MUL_SHIFT)) u_misc (
      .a(op_a), .b(op_b), .sel(sub_op), .y(misc_q)
   );

   // Result select and per-group flag policy
   always_comb begin
      result = '0;
      flag_v = 1'b0;
      flag_c = 1'b0;
      zn_en  = 1'b0;
      case (grp)
         GRP_ARITH: begin
            result = sum_q;
            flag_v = add_v;
            flag_c = add_c;
            zn_en  = 1'b1;
         end
         GRP_LOGIC: begin
            result = log_q;
            zn_en  = 1'b1;
         end
         GRP_MISC: begin
            result = misc_q;
            zn_en  = ~sub_op[1];
         end
         default: ;
      endcase
      flag_z = zn_en & (result == '0);
      flag_n = zn_en & result[W-1];
   end

   always_comb begin
      AST_ZN_EXCLUSIVE: assert (!(flag_z && flag_n)) else $error("z and n");   // R5
      if (opcode[3:2] != 2'b00) begin
         AST_NO_VC_OUTSIDE_ARITH: assert (!flag_v && !flag_c) else $error("v/c set");   // R6
      end
      if (opcode == 4'hA || opcode == 4'hB) begin
         AST_SHIFT_FLAGS_CLEAR: assert (!flag_z && !flag_n) else $error("shift flags");   // R9
      end
      if (opcode[3:2] == 2'b11) begin
         AST_UNUSED_ZERO: assert (result == '0 && !flag_v && !flag_z && !flag_c && !flag_n) else $error("unused op");   // R10
      end
   end
endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
   logic       clk = 1'b0;
   logic [7:0] a, b;
   logic [3:0] op;
   logic [7:0] res;
   logic       fv, fz, fc, fn;
   int         n_chk  = 0;
   int         n_fail = 0;
   bit         done   = 1'b0;

   always #5 clk = ~clk;

   alu8_core u0 (
      .op_a(a), .op_b(b), .opcode(op),
      .result(res), .flag_v(fv), .flag_z(fz), .flag_c(fc), .flag_n(fn)
   );

   // Reference model built from the requirements; returns {result, V, Z, C, N}
   function automatic logic [11:0] model(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y);
      int  sx, sy, s, sv;
      logic [7:0] r;
      logic v, c, zn;
      sx = int'($signed(x));
      sy = int'($signed(y));
      v = 0; c = 0; zn = 1; r = 8'h00; s = 0; sv = 0;
      case (o)
         4'h0: begin s = int'(x) + int'(y);             sv = sx + sy; end
         4'h1: begin s = int'(x) + (255 - int'(y)) + 1; sv = sx - sy; end
         4'h2: begin s = int'(x) + 255;                 sv = sx - 1;  end
         4'h3: begin s = (255 - int'(x)) + 1;           sv = -sx;     end
         4'h4: r = x | y;
         4'h5: r = ~(x & y);
         4'h6: r = ~(x ^ y);
         4'h7: r = ~x;
         4'h8: r = 8'((int'(y) * 8) % 256);
         4'h9: r = 8'(sx % 16);
         4'hA: begin r = 8'((int'(y) * 2) % 256); zn = 0; end
         4'hB: begin r = 8'(int'(y) / 2 + (int'(y[0]) * 128)); zn = 0; end
         default: begin r = 8'h00; zn = 0; end
      endcase
      if (o < 4'h4) begin
         r = 8'(s % 256);
         c = (s > 255);
         v = (sv > 127) || (sv < -128);
      end
      return {r, v, zn && (r == 8'h00), c, zn && r[7]};
   endfunction

   task automatic check(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y, input string req);
      logic [11:0] exp, act;
      @(negedge clk);
      op = o; a = x; b = y;
      #1;
      exp = model(o, x, y);
      act = {res, fv, fz, fc, fn};
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s op=%h a=%h b=%h: actual res=%h vzcn=%b, expected res=%h vzcn=%b",
                  req, o, x, y, act[11:4], act[3:0], exp[11:4], exp[3:0]);
      end
   endtask

   task automatic check_lit(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                            input logic [7:0] er, input logic [3:0] ef, input string req);
      @(negedge clk);
      op = o; a = x; b = y;
      #1;
      n_chk++;
      if ({res, fv, fz, fc, fn} !== {er, ef}) begin
         n_fail++;
         $display("FAIL %s op=%h a=%h b=%h: actual res=%h vzcn=%b, expected res=%h vzcn=%b",
                  req, o, x, y, res, {fv, fz, fc, fn}, er, ef);
      end
   endtask

   localparam logic [7:0] PATS [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'hAA, 8'h55, 8'hCB};

   task automatic t_sweep(input logic [3:0] o, input string req);
      for (int i = 0; i < 8; i++)
         for (int j = 0; j < 8; j++)
            check(o, PATS[i], PATS[j], req);
   endtask

   task automatic t_add;
      check_lit(4'h0, 8'h7F, 8'h01, 8'h80, 4'b1001, "R1");
      check_lit(4'h0, 8'hFF, 8'h01, 8'h00, 4'b0110, "R1 R5");
      t_sweep(4'h0, "R1");
   endtask

   task automatic t_sub;
      check_lit(4'h1, 8'h80, 8'h01, 8'h7F, 4'b1010, "R2");
      check_lit(4'h1, 8'h05, 8'h05, 8'h00, 4'b0110, "R2 R5");
      t_sweep(4'h1, "R2");
   endtask

   task automatic t_dec;
      check_lit(4'h2, 8'h00, 8'h33, 8'hFF, 4'b0001, "R3");
      check_lit(4'h2, 8'h80, 8'h00, 8'h7F, 4'b1010, "R3");
      t_sweep(4'h2, "R3");
   endtask

   task automatic t_neg;
      check_lit(4'h3, 8'h00, 8'h00, 8'h00, 4'b0110, "R4");
      check_lit(4'h3, 8'h80, 8'h00, 8'h80, 4'b1001, "R4");
      t_sweep(4'h3, "R4");
   endtask

   task automatic t_logic;
      check_lit(4'h4, 8'hAA, 8'h55, 8'hFF, 4'b0001, "R6");
      check_lit(4'h5, 8'hFF, 8'hFF, 8'h00, 4'b0100, "R6 R5");
      for (int o = 4; o < 8; o++) t_sweep(4'(o), "R6");
   endtask

   task automatic t_mul8;
      check_lit(4'h8, 8'h00, 8'hF3, 8'h98, 4'b0001, "R7");
      check_lit(4'h8, 8'h11, 8'h20, 8'h00, 4'b0100, "R7 R5");
      t_sweep(4'h8, "R7");
   endtask

   task automatic t_rem16;
      check_lit(4'h9, 8'hCB, 8'h57, 8'hFB, 4'b0001, "R8");
      check_lit(4'h9, 8'hF0, 8'h00, 8'h00, 4'b0100, "R8");
      check_lit(4'h9, 8'h3D, 8'h00, 8'h0D, 4'b0000, "R8");
      t_sweep(4'h9, "R8");
   endtask

   task automatic t_shift;
      check_lit(4'hA, 8'h00, 8'h9D, 8'h3A, 4'b0000, "R9");
      check_lit(4'hB, 8'h00, 8'h75, 8'hBA, 4'b0000, "R9");
      check_lit(4'hA, 8'h00, 8'h80, 8'h00, 4'b0000, "R9");
      t_sweep(4'hA, "R9");
      t_sweep(4'hB, "R9");
   endtask

   task automatic t_unused;
      for (int o = 12; o < 16; o++) begin
         check_lit(4'(o), 8'hFF, 8'hFF, 8'h00, 4'b0000, "R10");
         check_lit(4'(o), 8'h80, 8'h7F, 8'h00, 4'b0000, "R10");
      end
   endtask

   // R11: outputs settle with no clock edge between input change and sample
   task automatic t_comb;
      @(negedge clk);
      op = 4'h0; a = 8'h10; b = 8'h20;
      #1;
      n_chk++;
      if (res !== 8'h30) begin
         n_fail++;
         $display("FAIL R11 first: actual %h expected 30", res);
      end
      #1;
      b = 8'h01;
      #1;
      n_chk++;
      if (res !== 8'h11) begin
         n_fail++;
         $display("FAIL R11 second: actual %h expected 11", res);
      end
   endtask

   initial begin
      op = 4'h0; a = 8'h00; b = 8'h00;
      #2;
      n_chk++;
      if ({res, fv, fz, fc, fn} !== {8'h00, 4'b0100}) begin
         n_fail++;
         $display("FAIL R5 initial: actual res=%h vzcn=%b expected res=00 vzcn=0100",
                  res, {fv, fz, fc, fn});
      end
      t_add;
      t_sub;
      t_dec;
      t_neg;
      t_logic;
      t_mul8;
      t_rem16;
      t_shift;
      t_unused;
      t_comb;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule